// File: doc/BRIEF.md
# Pointer-Redirected Register File

This block is the byte-wide data memory of a small processor core. The core reaches every location through one port: an address, write data, a write enable that acts on the rising clock edge, and read data that follows the address without a clock. Most addresses are plain storage. A few are fixed special locations: the accumulator, the status location and two pointer registers.

Two addresses have no storage behind them. They are windows. Any read or write to a window is sent on to the location whose address sits in that window's pointer register. Software walks through a table by stepping the pointer and always touching the same window address. Only one location moves per access, so a copy from one window to the other is done in two steps through the accumulator.

A pointer can aim at a window, its own or the other one. The access then reads as zero, and a write through it changes nothing anywhere. The accumulator value is also driven out on its own port for the arithmetic datapath.

Top module: `ptr_regfile`

## Requirements
- R1: Fixed map. Window 0 is at 00H, pointer 0 at 01H, window 1 at 02H, pointer 1 at 03H, the accumulator at 05H and the status location at 0AH. Every other address is general storage that reads back the last value written to it.
- R2: A read or write at 00H acts on the location addressed by pointer 0. A read or write at 02H acts on the location addressed by pointer 1.
- R3: If the address held in the selected pointer is 00H or 02H, a read through the window returns 00H.
- R4: If the address held in the selected pointer is 00H or 02H, a write through the window changes no pointer, no accumulator and no storage location.
- R5: Both pointers can be read and written at their own addresses. They can also be reached through a window, for example pointer 0 holding 01H makes window 0 act on pointer 0 itself.
- R6: A write that resolves to 05H loads the accumulator. The accumulator reads back at 05H, and its value is always present on `acc_o`.
- R7: The status location at 0AH keeps and returns written data, whether it is reached directly or through a pointer.
- R8: A write takes effect at the rising clock edge while `we_i` is 1. With `we_i` at 0, no location changes. Read data follows the address in the same cycle.
- R9: While `rst_ni` is 0, both pointers and the accumulator are 00H. The reset is asynchronous.
- R10: A write changes only the one location its address resolves to. A write through a window leaves the pointer itself unchanged, unless the pointer is its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable for the current address |
| addr_i | input | 8 | Location address, which may be a window |
| wdata_i | input | 8 | Data to write |
| rdata_o | output | 8 | Combinational read data of the resolved location |
| acc_o | output | 8 | Current accumulator value |

## Verification
The bench aims pointers at windows: its own window, the other window, and its own pointer address. A design that forwards a window-to-window access would return stale data, or would corrupt a pointer on a write that should be ignored. It sends writes through a window to the accumulator and to the status location. It then checks that those special locations, and not the general storage behind them, took the value, and that the pointer itself did not move. A second reset in the middle of the run shows whether pointers and accumulator clear without a clock edge, and a held write with the enable low shows whether anything leaks into storage.

// File: rtl/ptr_regfile_pkg.sv
package ptr_regfile_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int NUM_PTR = 2;
    localparam logic [7:0] ACC_ADDR  = 8'h05;
    localparam logic [7:0] STAT_ADDR = 8'h0A;

    // window i sits at 2*i, its pointer at 2*i+1
    function automatic int win_addr(input int idx);
        return 2 * idx;
    endfunction

    function automatic int ptr_addr(input int idx);
        return 2 * idx + 1;
    endfunction
endpackage

// File: rtl/ptr_regfile_resolve.sv
module ptr_regfile_resolve
    import ptr_regfile_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NP = NUM_PTR
) (
    input  logic [AW-1:0]         addr_i,
    input  logic [NP-1:0][DW-1:0] ptr_i,
    output logic [AW-1:0]         eff_o,
    output logic                  void_o
);
    always_comb begin
        eff_o = addr_i;
        for (int i = 0; i < NP; i++) begin
            if (addr_i == AW'(win_addr(i))) begin
                eff_o = AW'(ptr_i[i]);
            end
        end
    end

    // a resolved address can only equal a window when a pointer aimed there
    always_comb begin
        void_o = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (eff_o == AW'(win_addr(i))) begin
                void_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ptr_regfile_store.sv
module ptr_regfile_store
    import ptr_regfile_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NP = NUM_PTR
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  we_i,
    input  logic [AW-1:0]         eff_i,
    input  logic                  void_i,
    input  logic [DW-1:0]         wdata_i,
    output logic [DW-1:0]         rdata_o,
    output logic [NP-1:0][DW-1:0] ptr_o,
    output logic [DW-1:0]         acc_o
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [NP-1:0][DW-1:0] ptr;
        logic [DW-1:0]         acc;
    } regs_t;

    regs_t         regs_d, regs_q;
    logic          ram_we_d;
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        logic special;
        regs_d   = regs_q;
        ram_we_d = 1'b0;
        special  = 1'b0;
        if (we_i && !void_i) begin
            for (int i = 0; i < NP; i++) begin
                if (eff_i == AW'(ptr_addr(i))) begin
                    regs_d.ptr[i] = wdata_i;
                    special       = 1'b1;
                end
            end
            if (eff_i == AW'(ACC_ADDR)) begin
                regs_d.acc = wdata_i;
                special    = 1'b1;
            end
            ram_we_d = !special;
        end
    end

    always_comb begin
        rdata_o = mem_q[eff_i];
        for (int i = 0; i < NP; i++) begin
            if (eff_i == AW'(ptr_addr(i))) begin
                rdata_o = regs_q.ptr[i];
            end
        end
        if (eff_i == AW'(ACC_ADDR)) begin
            rdata_o = regs_q.acc;
        end
        if (void_i) begin
            rdata_o = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (ram_we_d) begin
            mem_q[eff_i] <= wdata_i;
        end
    end

    assign ptr_o = regs_q.ptr;
    assign acc_o = regs_q.acc;

    // R4: a write through a window aimed at a window leaves registers alone
    p_void_write_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && void_i) |=> $stable(regs_q));

    // R8: with the enable low nothing moves
    p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(regs_q));

    // R6: resolved accumulator write loads the accumulator
    p_acc_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && !void_i && eff_i == AW'(ACC_ADDR)) |=> (acc_o == $past(wdata_i)));

    for (genvar g = 0; g < NP; g++) begin : g_ptr_chk
        // R5: resolved pointer write loads that pointer
        p_ptr_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (we_i && !void_i && eff_i == AW'(ptr_addr(g))) |=> (ptr_o[g] == $past(wdata_i)));
        // R10: writes elsewhere leave the pointer untouched
        p_ptr_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (we_i && eff_i != AW'(ptr_addr(g))) |=> $stable(ptr_o[g]));
    end
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
    import ptr_regfile_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NP = NUM_PTR
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] acc_o
);
    logic [NP-1:0][DW-1:0] ptr_q;
    logic [AW-1:0]         eff_addr;
    logic                  eff_void;

    ptr_regfile_resolve #(.DW(DW), .AW(AW), .NP(NP)) i_resolve (
        .addr_i (addr_i),
        .ptr_i  (ptr_q),
        .eff_o  (eff_addr),
        .void_o (eff_void)
    );

    ptr_regfile_store #(.DW(DW), .AW(AW), .NP(NP)) i_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we_i),
        .eff_i   (eff_addr),
        .void_i  (eff_void),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .ptr_o   (ptr_q),
        .acc_o   (acc_o)
    );

    // R3: a window aimed at a window reads as zero
    p_void_read_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eff_void |-> (rdata_o == '0));

    // R2: a direct (non-window) address is never reported void
    p_direct_not_void_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i != AW'(win_addr(0)) && addr_i != AW'(win_addr(1))) |-> !eff_void);
endmodule

// File: tb/test_ptr_regfile.sv
module test_ptr_regfile;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       we_i = 1'b0;
    logic [7:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic [7:0] acc_o;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    ptr_regfile i_ptr_regfile (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .acc_o(acc_o)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk_i);
        addr_i = a; wdata_i = d; we_i = 1'b1;
        @(posedge clk_i);
        #1 we_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk_i);
        addr_i = a; we_i = 1'b0;
        #1 chk(rdata_o, exp, tag);
    endtask

    task automatic t_reset();
        rst_ni = 1'b0;
        addr_i = 8'h01;
        #1 chk(rdata_o, 8'h00, "R9 pointer 0 in reset");
        chk(acc_o, 8'h00, "R9 acc in reset");
        repeat (3) @(posedge clk_i);
        @(negedge clk_i) rst_ni = 1'b1;
        rd(8'h03, 8'h00, "R9 pointer 1 after reset");
        rd(8'h05, 8'h00, "R9 acc read after reset");
        rd(8'h00, 8'h00, "R3 window 0 aimed at 00H after reset");
    endtask

    task automatic t_direct();
        wr(8'h20, 8'hA5); wr(8'h7F, 8'h3C); wr(8'hFF, 8'h81);
        rd(8'h20, 8'hA5, "R1 storage 20H");
        rd(8'h7F, 8'h3C, "R1 storage 7FH");
        rd(8'hFF, 8'h81, "R1 storage FFH");
    endtask

    task automatic t_enable_low();
        @(negedge clk_i);
        addr_i = 8'h20; wdata_i = 8'hFF; we_i = 1'b0;
        repeat (2) @(posedge clk_i);
        rd(8'h20, 8'hA5, "R8 no write with enable low");
        @(negedge clk_i);
        addr_i = 8'h05; wdata_i = 8'h77; we_i = 1'b0;
        @(posedge clk_i);
        #1 chk(acc_o, 8'h00, "R8 acc held with enable low");
    endtask

    task automatic t_pointer();
        wr(8'h01, 8'h20);
        rd(8'h01, 8'h20, "R5 pointer 0 direct read");
        rd(8'h00, 8'hA5, "R2 window 0 read");
        wr(8'h03, 8'h7F);
        rd(8'h02, 8'h3C, "R2 window 1 read");
        wr(8'h00, 8'h11);
        rd(8'h20, 8'h11, "R2 window 0 write lands");
        wr(8'h02, 8'h22);
        rd(8'h7F, 8'h22, "R2 window 1 write lands");
        rd(8'h01, 8'h20, "R10 pointer 0 unchanged by window write");
        rd(8'h03, 8'h7F, "R10 pointer 1 unchanged by window write");
    endtask

    task automatic t_self_ref();
        wr(8'h01, 8'h00);
        rd(8'h00, 8'h00, "R3 window 0 aimed at itself");
        wr(8'h00, 8'h99);
        rd(8'h01, 8'h00, "R4 pointer 0 kept");
        rd(8'h03, 8'h7F, "R4 pointer 1 kept");
        rd(8'h20, 8'h11, "R4 storage kept");
        chk(acc_o, 8'h00, "R4 acc kept");
        wr(8'h01, 8'h02);
        rd(8'h00, 8'h00, "R3 window 0 aimed at window 1");
        wr(8'h00, 8'h55);
        rd(8'h03, 8'h7F, "R4 pointer 1 kept via cross window");
        wr(8'h03, 8'h00);
        rd(8'h02, 8'h00, "R3 window 1 aimed at window 0");
        wr(8'h01, 8'h01);
        rd(8'h00, 8'h01, "R5 window 0 reads pointer 0");
        wr(8'h00, 8'h30);
        rd(8'h01, 8'h30, "R5 window 0 writes pointer 0");
    endtask

    task automatic t_acc();
        wr(8'h05, 8'h5A);
        chk(acc_o, 8'h5A, "R6 acc port after direct write");
        rd(8'h05, 8'h5A, "R6 acc direct read");
        wr(8'h03, 8'h05);
        rd(8'h02, 8'h5A, "R6 acc read through window 1");
        wr(8'h02, 8'hC3);
        chk(acc_o, 8'hC3, "R6 acc written through window 1");
        rd(8'h03, 8'h05, "R10 pointer 1 kept after acc write");
        rd(8'h20, 8'h11, "R10 storage 20H kept");
        rd(8'h7F, 8'h22, "R10 storage 7FH kept");
    endtask

    task automatic t_status();
        wr(8'h0A, 8'h0F);
        rd(8'h0A, 8'h0F, "R7 status direct");
        wr(8'h01, 8'h0A);
        rd(8'h00, 8'h0F, "R7 status through window 0");
        wr(8'h00, 8'hF0);
        rd(8'h0A, 8'hF0, "R7 status written through window 0");
        chk(acc_o, 8'hC3, "R10 acc kept after status write");
    endtask

    task automatic t_mid_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        addr_i = 8'h01;
        #1 chk(rdata_o, 8'h00, "R9 async clear pointer 0");
        chk(acc_o, 8'h00, "R9 async clear acc");
        addr_i = 8'h03;
        #1 chk(rdata_o, 8'h00, "R9 async clear pointer 1");
        @(negedge clk_i) rst_ni = 1'b1;
    endtask

    initial begin
        t_reset();
        t_direct();
        t_enable_low();
        t_pointer();
        t_self_ref();
        t_acc();
        t_status();
        t_mid_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule